// File: doc/BRIEF.md
# Auto-Precharge Inter-Bank Spacing Guard

This block sits in the command path of a DDR SDRAM controller. It checks each command before it goes to the memory. After a read or write that carries auto precharge, a command to a different bank must not issue until a minimum number of clock cycles has passed. That minimum depends on two things: the kind of auto-precharge access that came before, and the kind of command that follows. The guard raises `cmdAllowed` for every command that keeps this spacing. It lowers `cmdAllowed` for a command that comes too early, and then pulses `violation` in the next cycle.

Only the most recent accepted auto-precharge access is tracked. A rejected command does not count as issued and changes no state. The required gaps are built from three configuration inputs: the burst length, the CAS latency in whole cycles, and the write-to-read delay in whole cycles. Spacing is measured from cycle t0, the cycle in which the auto-precharge command was presented and allowed. A follower presented in cycle t0+k with a gap of N is allowed exactly when k >= N.

Top module: `ap_spacing_guard`

## Requirements
- R1: After reset, `violation` is low and no access is tracked. Every command is allowed until a read or write with `cmdAp`=1 has been accepted.
- R2: `cmdAllowed` is high in every cycle where `cmdValid` is low.
- R3: After an accepted write with auto precharge (`cmdType`=01, `cmdAp`=1), a read (`cmdType`=00) to another bank needs a gap of 1 + `cfgBurst`/2 + `cfgWtr` cycles.
- R4: After an accepted write with auto precharge, a write (`cmdType`=01) to another bank needs a gap of `cfgBurst`/2 cycles.
- R5: After an accepted read with auto precharge (`cmdType`=00, `cmdAp`=1), a read to another bank needs a gap of `cfgBurst`/2 cycles.
- R6: After an accepted read with auto precharge, a write to another bank needs a gap of `cfgCas` + `cfgBurst`/2 cycles.
- R7: A precharge (`cmdType`=10) or activate (`cmdType`=11) to another bank needs a gap of 1 cycle, whichever auto-precharge access came before. It is therefore allowed in any later cycle.
- R8: A command to the same bank as the tracked access is always allowed.
- R9: For reads and writes that follow, the gap does not depend on their own `cmdAp`. For precharge and activate, `cmdAp` is ignored.
- R10: Only the most recent allowed read or write with `cmdAp`=1 sets the tracked bank and type. Rejected commands and commands without auto precharge leave the tracking unchanged.
- R11: `violation` is high in the cycle after each cycle with `cmdValid`=1 and `cmdAllowed`=0, and low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdType | input | 2 | 00 read, 01 write, 10 precharge, 11 activate |
| cmdAp | input | 1 | Auto-precharge flag of the command |
| cmdBank | input | BANK_W | Bank address of the command |
| cfgBurst | input | BURST_W | Burst length: 2, 4 or 8 |
| cfgCas | input | CAS_W | CAS latency in whole cycles |
| cfgWtr | input | WTR_W | Write-to-read delay in whole cycles |
| cmdAllowed | output | 1 | The presented command keeps the spacing rules |
| violation | output | 1 | One-cycle pulse after a rejected command |

## Verification
The bench uses the default widths: four banks, a 4-bit burst input, and 3-bit CAS and write-to-read inputs. It sweeps nine configurations that combine burst lengths 2, 4 and 8 with CAS and write-to-read values from 1 to 4. This gives gaps from 1 up to 9 cycles. For every pair of preceding and following command types, it probes the follower at each offset from one cycle up to past the gap. Every boundary cycle of every formula is therefore seen on both sides. A random phase mixes banks and flags so that tracking replacement, rejected auto-precharge commands and same-bank traffic occur in many orders.

// File: rtl/apsg_pkg.sv
`timescale 1ns/1ps
package apsg_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_PRE   = 2'b10,
    CMD_ACT   = 2'b11
  } cmdKind_e;

  // follower classes, one spacing counter each
  localparam int NCLS    = 3;
  localparam int CLS_RD  = 0;
  localparam int CLS_WR  = 1;
  localparam int CLS_OTH = 2;

  typedef struct packed {
    logic loadRdAp;
    logic loadWrAp;
  } dpCtrl_t;
endpackage

// File: rtl/apsg_dp.sv
`timescale 1ns/1ps
module apsg_dp
  import apsg_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int BURST_W = 4,
  parameter int CAS_W   = 3,
  parameter int WTR_W   = 3,
  parameter int GAP_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [BURST_W-1:0] cfgBurst,
  input  logic [CAS_W-1:0]  cfgCas,
  input  logic [WTR_W-1:0]  cfgWtr,
  output logic              tracked,
  output logic [BANK_W-1:0] trackBank,
  output logic [NCLS-1:0]   clsClear
);
  logic [GAP_W-1:0] halfBurst;
  logic [GAP_W-1:0] casExt;
  logic [GAP_W-1:0] wtrExt;
  logic [GAP_W-1:0] gapAfterWr [NCLS];
  logic [GAP_W-1:0] gapAfterRd [NCLS];
  logic             loadAny;

  assign halfBurst = GAP_W'(cfgBurst >> 1);
  assign casExt    = GAP_W'(cfgCas);
  assign wtrExt    = GAP_W'(cfgWtr);
  assign loadAny   = ctl.loadRdAp | ctl.loadWrAp;

  always_comb begin
    gapAfterWr[CLS_RD]  = GAP_W'(1) + halfBurst + wtrExt;
    gapAfterWr[CLS_WR]  = halfBurst;
    gapAfterWr[CLS_OTH] = GAP_W'(1);
    gapAfterRd[CLS_RD]  = halfBurst;
    gapAfterRd[CLS_WR]  = casExt + halfBurst;
    gapAfterRd[CLS_OTH] = GAP_W'(1);
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [GAP_W-1:0] remain;
    logic [GAP_W-1:0] gapSel;

    assign gapSel = ctl.loadWrAp ? gapAfterWr[c] : gapAfterRd[c];

    // remain counts cycles still missing; next cycle is elapsed one
    always_ff @(posedge clk) begin
      if (!rstN) begin
        remain <= '0;
      end else if (loadAny) begin
        remain <= (gapSel == '0) ? '0 : gapSel - GAP_W'(1);
      end else if (remain != '0) begin
        remain <= remain - GAP_W'(1);
      end
    end

    assign clsClear[c] = (remain == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tracked   <= 1'b0;
      trackBank <= '0;
    end else if (loadAny) begin
      tracked   <= 1'b1;
      trackBank <= cmdBank;
    end
  end
endmodule

// File: rtl/apsg_ctrl.sv
`timescale 1ns/1ps
module apsg_ctrl
  import apsg_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdType,
  input  logic              cmdAp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              tracked,
  input  logic [BANK_W-1:0] trackBank,
  input  logic [NCLS-1:0]   clsClear,
  output logic              cmdAllowed,
  output logic              violation,
  output dpCtrl_t           ctl
);
  cmdKind_e kind;
  int unsigned clsIdx;
  logic needCheck;
  logic accept;

  assign kind = cmdKind_e'(cmdType);

  always_comb begin
    unique case (kind)
      CMD_READ:  clsIdx = CLS_RD;
      CMD_WRITE: clsIdx = CLS_WR;
      default:   clsIdx = CLS_OTH;
    endcase
  end

  assign needCheck  = cmdValid && tracked && (cmdBank != trackBank);
  assign cmdAllowed = !needCheck || clsClear[clsIdx];
  assign accept     = cmdValid && cmdAllowed;

  always_comb begin
    ctl.loadRdAp = accept && cmdAp && (kind == CMD_READ);
    ctl.loadWrAp = accept && cmdAp && (kind == CMD_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) violation <= 1'b0;
    else       violation <= cmdValid && !cmdAllowed;
  end
endmodule

// File: rtl/ap_spacing_guard.sv
`timescale 1ns/1ps
module ap_spacing_guard
  import apsg_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int BURST_W = 4,
  parameter int CAS_W   = 3,
  parameter int WTR_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdType,
  input  logic               cmdAp,
  input  logic [BANK_W-1:0]  cmdBank,
  input  logic [BURST_W-1:0] cfgBurst,
  input  logic [CAS_W-1:0]   cfgCas,
  input  logic [WTR_W-1:0]   cfgWtr,
  output logic               cmdAllowed,
  output logic               violation
);
  localparam int WIDEST = (BURST_W > CAS_W) ? ((BURST_W > WTR_W) ? BURST_W : WTR_W)
                                            : ((CAS_W > WTR_W) ? CAS_W : WTR_W);
  localparam int GAP_W  = WIDEST + 2;

  dpCtrl_t           ctl;
  logic              tracked;
  logic [BANK_W-1:0] trackBank;
  logic [NCLS-1:0]   clsClear;

  apsg_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdAp(cmdAp), .cmdBank(cmdBank), .tracked(tracked),
    .trackBank(trackBank), .clsClear(clsClear),
    .cmdAllowed(cmdAllowed), .violation(violation), .ctl(ctl)
  );

  apsg_dp #(
    .BANK_W(BANK_W), .BURST_W(BURST_W), .CAS_W(CAS_W),
    .WTR_W(WTR_W), .GAP_W(GAP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdBank(cmdBank),
    .cfgBurst(cfgBurst), .cfgCas(cfgCas), .cfgWtr(cfgWtr),
    .tracked(tracked), .trackBank(trackBank), .clsClear(clsClear)
  );
endmodule

// File: rtl/apsg_checker.sv
`timescale 1ns/1ps
module apsg_checker #(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdType,
  input logic              cmdAp,
  input logic [BANK_W-1:0] cmdBank,
  input logic              cmdAllowed,
  input logic              violation
);
  logic              haveAp;
  logic [BANK_W-1:0] lastBank;
  logic              wrApJust;
  logic              rejectPrev;
  logic              apAccept;

  assign apAccept = cmdValid && cmdAllowed && cmdAp && !cmdType[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveAp     <= 1'b0;
      lastBank   <= '0;
      wrApJust   <= 1'b0;
      rejectPrev <= 1'b0;
    end else begin
      if (apAccept) begin
        haveAp   <= 1'b1;
        lastBank <= cmdBank;
      end
      wrApJust   <= apAccept && (cmdType == 2'b01);
      rejectPrev <= cmdValid && !cmdAllowed;
    end
  end

  a_r2_idle_allowed: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> cmdAllowed);

  a_r1_untracked_allowed: assert property (@(posedge clk) disable iff (!rstN)
    !haveAp |-> cmdAllowed);

  a_r7_pre_act_allowed: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdType[1]) |-> cmdAllowed);

  a_r8_same_bank_allowed: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && haveAp && cmdBank == lastBank) |-> cmdAllowed);

  a_r3_read_after_wrap_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (wrApJust && cmdValid && cmdType == 2'b00 && cmdBank != lastBank) |-> !cmdAllowed);

  a_r11_viol_follows_reject: assert property (@(posedge clk) disable iff (!rstN)
    rejectPrev |-> violation);

  a_r11_no_spurious_viol: assert property (@(posedge clk) disable iff (!rstN)
    !rejectPrev |-> !violation);
endmodule

bind ap_spacing_guard apsg_checker #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
  .cmdAp(cmdAp), .cmdBank(cmdBank), .cmdAllowed(cmdAllowed),
  .violation(violation)
);

// File: tb/ap_spacing_guard_test.sv
`timescale 1ns/1ps
module ap_spacing_guard_test;
  localparam int BANK_W = 2, BURST_W = 4, CAS_W = 3, WTR_W = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, cmdValid, cmdAp, cmdAllowed, violation;
  logic [1:0] cmdType;
  logic [BANK_W-1:0] cmdBank;
  logic [BURST_W-1:0] cfgBurst;
  logic [CAS_W-1:0] cfgCas;
  logic [WTR_W-1:0] cfgWtr;

  ap_spacing_guard #(.BANK_W(BANK_W), .BURST_W(BURST_W), .CAS_W(CAS_W), .WTR_W(WTR_W)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType), .cmdAp(cmdAp),
    .cmdBank(cmdBank), .cfgBurst(cfgBurst), .cfgCas(cfgCas), .cfgWtr(cfgWtr),
    .cmdAllowed(cmdAllowed), .violation(violation)
  );

  int checks = 0, failures = 0;
  int cyc = 0, lastCyc = 0, lastBank = 0;
  bit have = 0, lastWr = 0, prevRej = 0, finished = 0;
  string forceTag = "";

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cyc=%0d actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  function automatic int gapFor(bit prevWr, int t);
    int half = int'(cfgBurst) / 2;
    if (t >= 2) return 1;
    if (prevWr) return (t == 0) ? 1 + half + int'(cfgWtr) : half;
    return (t == 0) ? half : int'(cfgCas) + half;
  endfunction

  task automatic step(bit v, int t, bit ap, int b);
    bit expAllowed;
    string tag;
    @(negedge clk);
    cmdValid = v; cmdType = 2'(t); cmdAp = ap; cmdBank = BANK_W'(b);
    #1;
    expAllowed = 1'b1;
    tag = "R2";
    if (v) begin
      if (!have) tag = "R1";
      else if (b == lastBank) tag = "R8";
      else begin
        expAllowed = (cyc - lastCyc) >= gapFor(lastWr, t);
        if (t >= 2) tag = ap ? "R7/R9" : "R7";
        else if (lastWr) tag = (t == 0) ? "R3" : "R4";
        else tag = (t == 0) ? "R5" : "R6";
        if (ap && t < 2) tag = {tag, "/R9"};
      end
    end
    if (forceTag != "") tag = forceTag;
    check(cmdAllowed, expAllowed, tag);
    check(violation, prevRej, "R11");
    if (v && expAllowed && ap && t < 2) begin
      have = 1'b1; lastWr = (t == 1); lastCyc = cyc; lastBank = b;
    end
    prevRej = v && !expAllowed;
    cyc++;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cmdValid = 1'b0; cmdType = 2'b00; cmdAp = 1'b0; cmdBank = '0;
    repeat (2) @(negedge clk);
    #1;
    check(violation, 1'b0, "R1");
    rstN = 1'b1;
    have = 0; prevRej = 0; cyc = 0; lastCyc = 0; lastBank = 0;
  endtask

  initial begin
    #900000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bls[3] = '{2, 4, 8};
    int cw[3][2] = '{'{2, 1}, '{3, 2}, '{1, 4}};
    rstN = 1'b0; cmdValid = 0; cmdType = 0; cmdAp = 0; cmdBank = 0;
    cfgBurst = 4'd2; cfgCas = 3'd2; cfgWtr = 3'd1;
    for (int bi = 0; bi < 3; bi++) begin
      for (int ci = 0; ci < 3; ci++) begin
        cfgBurst = BURST_W'(bls[bi]); cfgCas = CAS_W'(cw[ci][0]); cfgWtr = WTR_W'(cw[ci][1]);
        doReset();
        // R1: commands to any bank before tracking starts
        step(1, 0, 0, 1); step(1, 1, 1, 2); // write with ap to bank 2 now tracked
        step(0, 0, 0, 0);
        // R3..R9 sweep of every pair and offset
        for (int pw = 0; pw < 2; pw++) begin
          for (int ft = 0; ft < 4; ft++) begin
            for (int fa = 0; fa < 2; fa++) begin
              for (int k = 1; k <= 14; k++) begin
                step(0, 0, 0, 0); step(0, 0, 0, 0);
                step(1, pw, 1, 0);
                for (int i = 1; i < k; i++) step(0, 0, 0, 0);
                step(1, ft, fa, 1);
                step(1, ft, fa, 0); // R8 same bank follow-up
              end
            end
          end
        end
        // R10: a rejected ap read must not take over tracking
        for (int i = 0; i < 14; i++) step(0, 0, 0, 0);
        step(1, 1, 1, 0);
        forceTag = "R10";
        step(1, 0, 1, 1);
        step(1, 0, 0, 1);
        forceTag = "";
        // R10: non-ap read leaves tracking on bank 3
        for (int i = 0; i < 14; i++) step(0, 0, 0, 0);
        step(1, 0, 1, 3);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 2);
        forceTag = "R10";
        step(1, 1, 0, 3);
        forceTag = "";
        // random mix
        for (int i = 0; i < 300; i++)
          step(($urandom % 4) != 0, int'($urandom % 4), bit'($urandom % 2), int'($urandom % 4));
      end
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule